// File: doc/BRIEF.md
# Int8 Vector-Matrix Tile Multiply-Accumulate Core

This core performs one tile operation per clock. An operation takes a row of sixteen signed 8-bit activations from an input memory and a sixteen-by-sixteen signed 8-bit weight tile from a weight memory. The weight tile is held with its outer index selecting the output lane. The core forms sixteen dot products and adds them into one row of a sixteen-lane signed 32-bit accumulator memory. A clear mode can be used instead of accumulating. In that mode the operation writes zeros to its accumulator row and leaves the input and weight memories untouched.

A built-in loop sequencer runs a burst of operations from a single start pulse. The start pulse carries an extent and, for each of the three memories, a base address and a stride. Iteration i uses address base + i*stride, wrapped to the memory depth. Once the burst has finished, the core raises a one-cycle done pulse. A store port then reads accumulator rows back with a valid/ready request. It returns each row narrowed to sixteen packed 8-bit lanes. The input and weight memories are loaded through plain write ports.

Top module: `gemm_tile_core`

## Requirements
- R1: Output lane j of an operation adds sum over k of inp[k]*wgt[j][k] into lane j of the addressed accumulator row. Products and sums are signed, and the sum wraps modulo 2^32. Input element k sits at bits [8k+7:8k] of an input word. Weight element (j,k) sits at bits [8(16j+k)+7:8(16j+k)] of a weight word.
- R2: After reset, busy, done and st_rsp_valid are 0, and st_req_ready is 1.
- R3: A start accepted at a clock edge with extent n>0 holds busy high for the next n+1 cycles. It then gives done high for exactly one cycle with busy low, and every write has landed by then.
- R4: Iteration i of a burst uses addresses base+i*stride modulo the depth of each of the three memories.
- R5: Consecutive operations that target the same accumulator row accumulate correctly, with no gap between them.
- R6: In clear mode each operation writes zero to its accumulator row, whatever the input and weight memories hold. Other rows keep their values.
- R7: A store request accepted with st_req_valid and st_req_ready at an edge gives st_rsp_valid for one cycle after that edge. st_rsp_data holds the low 8 bits of each 32-bit lane, with lane 0 in bits [7:0], and there is no saturation.
- R8: While busy is high, st_req_ready is low and start is ignored.
- R9: A start with extent 0 performs no operation and gives done in the next cycle, with busy staying low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inp_wr_en | input | 1 | Input memory write enable |
| inp_wr_addr | input | LOG_INP | Input memory write address |
| inp_wr_data | input | BLK_IN*DW | Input vector, element k at byte k |
| wgt_wr_en | input | 1 | Weight memory write enable |
| wgt_wr_addr | input | LOG_WGT | Weight memory write address |
| wgt_wr_data | input | BLK_OUT*BLK_IN*DW | Weight tile, element (j,k) at byte 16j+k |
| start | input | 1 | Start a burst (taken when not busy) |
| clear_mode | input | 1 | Burst writes zero rows instead of accumulating |
| extent | input | EXT_W | Number of operations in the burst |
| acc_base | input | LOG_ACC | Accumulator base row |
| acc_stride | input | LOG_ACC | Accumulator row stride |
| inp_base | input | LOG_INP | Input base address |
| inp_stride | input | LOG_INP | Input address stride |
| wgt_base | input | LOG_WGT | Weight base address |
| wgt_stride | input | LOG_WGT | Weight address stride |
| busy | output | 1 | Burst in flight |
| done | output | 1 | One-cycle burst completion pulse |
| st_req_valid | input | 1 | Store read request |
| st_req_ready | output | 1 | Store request can be taken |
| st_req_addr | input | LOG_ACC | Accumulator row to read |
| st_rsp_valid | output | 1 | Narrowed row valid |
| st_rsp_data | output | BLK_OUT*DW | Narrowed row, lane 0 in the low byte |

## Verification
The bench builds the core with 16-entry memories on all three sides, 16 lanes and an 8-bit extent. At this size a full 16-step reduction into a single row is reachable, which exercises the forwarding path on every cycle. Strides of 3, 5 and 7 wrap all three address counters within a short burst. A weight tile with graded values pushes lane sums past the 8-bit range, so truncation shows up in the stored bytes.

// File: rtl/gemm_tile_core.sv
module gemm_tile_core #(
  parameter int BLK_IN  = 16,
  parameter int BLK_OUT = 16,
  parameter int DW      = 8,
  parameter int AW      = 32,
  parameter int LOG_INP = 4,
  parameter int LOG_WGT = 4,
  parameter int LOG_ACC = 4,
  parameter int EXT_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          inp_wr_en,
  input  logic [LOG_INP-1:0]            inp_wr_addr,
  input  logic [BLK_IN*DW-1:0]          inp_wr_data,
  input  logic                          wgt_wr_en,
  input  logic [LOG_WGT-1:0]            wgt_wr_addr,
  input  logic [BLK_OUT*BLK_IN*DW-1:0]  wgt_wr_data,
  input  logic                          start,
  input  logic                          clear_mode,
  input  logic [EXT_W-1:0]              extent,
  input  logic [LOG_ACC-1:0]            acc_base,
  input  logic [LOG_ACC-1:0]            acc_stride,
  input  logic [LOG_INP-1:0]            inp_base,
  input  logic [LOG_INP-1:0]            inp_stride,
  input  logic [LOG_WGT-1:0]            wgt_base,
  input  logic [LOG_WGT-1:0]            wgt_stride,
  output logic                          busy,
  output logic                          done,
  input  logic                          st_req_valid,
  output logic                          st_req_ready,
  input  logic [LOG_ACC-1:0]            st_req_addr,
  output logic                          st_rsp_valid,
  output logic [BLK_OUT*DW-1:0]         st_rsp_data
);
  localparam int IROW = BLK_IN * DW;
  localparam int WROW = BLK_OUT * IROW;
  localparam int AROW = BLK_OUT * AW;

  logic [IROW-1:0] inp_mem [0:(1<<LOG_INP)-1];
  logic [WROW-1:0] wgt_mem [0:(1<<LOG_WGT)-1];
  logic [AROW-1:0] acc_mem [0:(1<<LOG_ACC)-1];

  logic               run, clr_q;
  logic [EXT_W-1:0]   cnt, ext_q;
  logic [LOG_ACC-1:0] a_addr, a_step;
  logic [LOG_INP-1:0] i_addr, i_step;
  logic [LOG_WGT-1:0] w_addr, w_step;
  logic               s1_valid, s1_last, s1_clr;
  logic [LOG_ACC-1:0] s1_addr;
  logic [IROW-1:0]    inp_rd;
  logic [WROW-1:0]    wgt_rd;
  logic [AROW-1:0]    acc_rd, acc_old, acc_new;
  logic               fw_valid;
  logic [LOG_ACC-1:0] fw_addr;
  logic [AROW-1:0]    fw_data;
  logic               last_issue;

  assign busy         = run | s1_valid;
  assign st_req_ready = ~busy;
  assign last_issue   = run && (cnt == ext_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; clr_q <= 1'b0; cnt <= '0; ext_q <= '0;
      a_addr <= '0; a_step <= '0; i_addr <= '0; i_step <= '0;
      w_addr <= '0; w_step <= '0;
      s1_valid <= 1'b0; s1_last <= 1'b0; s1_clr <= 1'b0; s1_addr <= '0;
      fw_valid <= 1'b0; fw_addr <= '0; fw_data <= '0;
      done <= 1'b0; st_rsp_valid <= 1'b0;
    end else begin
      done         <= (s1_valid && s1_last) || (start && !busy && extent == '0);
      st_rsp_valid <= st_req_valid && st_req_ready;
      if (!busy && start) begin
        run    <= (extent != '0);
        cnt    <= '0;
        ext_q  <= extent;
        clr_q  <= clear_mode;
        a_addr <= acc_base; a_step <= acc_stride;
        i_addr <= inp_base; i_step <= inp_stride;
        w_addr <= wgt_base; w_step <= wgt_stride;
      end else if (run) begin
        cnt    <= cnt + 1'b1;
        a_addr <= a_addr + a_step;
        i_addr <= i_addr + i_step;
        w_addr <= w_addr + w_step;
        if (last_issue) run <= 1'b0;
      end
      s1_valid <= run;
      s1_last  <= last_issue;
      s1_clr   <= clr_q;
      s1_addr  <= a_addr;
      fw_valid <= s1_valid;
      fw_addr  <= s1_addr;
      fw_data  <= acc_new;
    end
  end

  always_ff @(posedge clk) begin
    if (inp_wr_en) inp_mem[inp_wr_addr] <= inp_wr_data;
    if (wgt_wr_en) wgt_mem[wgt_wr_addr] <= wgt_wr_data;
    if (s1_valid)  acc_mem[s1_addr]     <= acc_new;
    if (run && !clr_q) begin
      inp_rd <= inp_mem[i_addr];
      wgt_rd <= wgt_mem[w_addr];
    end
    acc_rd <= acc_mem[run ? a_addr : st_req_addr];
  end

  assign acc_old = (fw_valid && fw_addr == s1_addr) ? fw_data : acc_rd;

  always_comb begin
    for (int j = 0; j < BLK_OUT; j++) begin : g_lane
      logic signed [AW-1:0] sum, pa, pb;
      sum = acc_old[j*AW +: AW];
      for (int k = 0; k < BLK_IN; k++) begin
        pa  = AW'($signed(inp_rd[k*DW +: DW]));
        pb  = AW'($signed(wgt_rd[(j*BLK_IN+k)*DW +: DW]));
        sum = sum + pa * pb;
      end
      acc_new[j*AW +: AW] = s1_clr ? '0 : sum;
    end
  end

  for (genvar j = 0; j < BLK_OUT; j++) begin : g_narrow
    assign st_rsp_data[j*DW +: DW] = acc_rd[j*AW +: DW];
  end
endmodule

// File: rtl/gemm_tile_core_chk.sv
module gemm_tile_core_chk #(
  parameter int EXT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [EXT_W-1:0] extent,
  input logic             busy,
  input logic             done,
  input logic             st_req_valid,
  input logic             st_req_ready,
  input logic             st_rsp_valid
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && extent != '0) |=> busy); // R8
  AST_BUSY_BLOCKS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !st_req_ready); // R8
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req_valid && st_req_ready) |=> st_rsp_valid); // R7
  AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    st_rsp_valid |-> $past(st_req_valid && st_req_ready)); // R7
  AST_EMPTY_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && extent == '0) |=> (done && !busy)); // R9
endmodule

bind gemm_tile_core gemm_tile_core_chk #(.EXT_W(EXT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .extent(extent), .busy(busy),
  .done(done), .st_req_valid(st_req_valid), .st_req_ready(st_req_ready),
  .st_rsp_valid(st_rsp_valid)
);

// File: tb/gemm_tile_core_bench.sv
module gemm_tile_core_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic inp_wr_en = 0, wgt_wr_en = 0, start = 0, clear_mode = 0, st_req_valid = 0;
  logic [3:0] inp_wr_addr = 0, wgt_wr_addr = 0, st_req_addr = 0;
  logic [127:0] inp_wr_data = 0;
  logic [2047:0] wgt_wr_data = 0;
  logic [7:0] extent = 0;
  logic [3:0] acc_base = 0, acc_stride = 0, inp_base = 0, inp_stride = 0, wgt_base = 0, wgt_stride = 0;
  logic busy, done, st_req_ready, st_rsp_valid;
  logic [127:0] st_rsp_data;

  gemm_tile_core #(.BLK_IN(16), .BLK_OUT(16), .DW(8), .AW(32), .LOG_INP(4), .LOG_WGT(4),
                   .LOG_ACC(4), .EXT_W(8)) u_gemm_tile_core (.*);

  int inp_m [16][16];
  int wgt_m [16][16][16];
  int acc_m [16][16];
  int checks = 0, errors = 0;

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic load_inp(int a);
    @(negedge clk);
    inp_wr_en = 1; inp_wr_addr = 4'(a);
    for (int k = 0; k < 16; k++) inp_wr_data[k*8 +: 8] = 8'(inp_m[a][k]);
    @(negedge clk);
    inp_wr_en = 0;
  endtask

  task automatic load_wgt(int a);
    @(negedge clk);
    wgt_wr_en = 1; wgt_wr_addr = 4'(a);
    for (int j = 0; j < 16; j++)
      for (int k = 0; k < 16; k++) wgt_wr_data[(j*16+k)*8 +: 8] = 8'(wgt_m[a][j][k]);
    @(negedge clk);
    wgt_wr_en = 0;
  endtask

  task automatic burst(bit clr, int n, int ab, int as, int ib, int is, int wb, int ws, bit poke);
    for (int i = 0; i < n; i++) begin
      int a, ii, w;
      a = (ab + i*as) % 16; ii = (ib + i*is) % 16; w = (wb + i*ws) % 16;
      for (int j = 0; j < 16; j++) begin
        int s;
        s = 0;
        for (int k = 0; k < 16; k++) s += inp_m[ii][k] * wgt_m[w][j][k];
        acc_m[a][j] = clr ? 0 : acc_m[a][j] + s;
      end
    end
    @(negedge clk);
    start = 1; clear_mode = clr; extent = 8'(n);
    acc_base = 4'(ab); acc_stride = 4'(as); inp_base = 4'(ib); inp_stride = 4'(is);
    wgt_base = 4'(wb); wgt_stride = 4'(ws);
    @(negedge clk);
    start = 0;
    if (n == 0) begin
      chk(done === 1'b1 && busy === 1'b0, "R9", "empty burst done", {busy, done}, 2'b01);
    end else begin
      for (int c = 0; c <= n; c++) begin
        chk(busy === 1'b1 && done === 1'b0, "R3", "busy during burst", {busy, done}, 2'b10);
        chk(st_req_ready === 1'b0, "R8", "store blocked while busy", st_req_ready, 0);
        if (poke && c == 1) begin
          start = 1; clear_mode = 1; extent = 8'd2; acc_base = 4'(ab);
        end
        if (poke && c == 2) start = 0;
        @(negedge clk);
      end
      chk(done === 1'b1 && busy === 1'b0, "R3", "done after n+1 cycles", {busy, done}, 2'b01);
      @(negedge clk);
      chk(done === 1'b0, "R3", "done is one pulse", done, 0);
    end
  endtask

  task automatic read_row(int a, string req);
    logic [127:0] e;
    for (int j = 0; j < 16; j++) e[j*8 +: 8] = 8'(acc_m[a][j]);
    @(negedge clk);
    chk(st_req_ready === 1'b1, "R7", "store ready when idle", st_req_ready, 1);
    st_req_valid = 1; st_req_addr = 4'(a);
    @(negedge clk);
    st_req_valid = 0;
    chk(st_rsp_valid === 1'b1, "R7", "response valid", st_rsp_valid, 1);
    chk(st_rsp_data === e, req, $sformatf("row %0d data", a), st_rsp_data, e);
    @(negedge clk);
    chk(st_rsp_valid === 1'b0, "R7", "response one cycle", st_rsp_valid, 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && st_rsp_valid === 0 && st_req_ready === 1, "R2", "reset state",
        {busy, done, st_rsp_valid, st_req_ready}, 4'b0001);
    rst_n = 1;
    for (int a = 0; a < 16; a++) begin
      for (int k = 0; k < 16; k++) inp_m[a][k] = int'($urandom_range(0, 255)) - 128;
      for (int j = 0; j < 16; j++)
        for (int k = 0; k < 16; k++) wgt_m[a][j][k] = int'($urandom_range(0, 255)) - 128;
    end
    for (int k = 0; k < 16; k++) inp_m[13][k] = 1;
    for (int j = 0; j < 16; j++) for (int k = 0; k < 16; k++) wgt_m[13][j][k] = j - 8;
    for (int a = 0; a < 16; a++) begin load_inp(a); load_wgt(a); end

    // R6: clear every row
    burst(1, 16, 0, 1, 0, 0, 0, 0, 0);
    for (int a = 0; a < 16; a++) read_row(a, "R6");

    // R5 R1: sixteen back-to-back steps into one row
    burst(0, 16, 2, 0, 0, 1, 0, 1, 0);
    read_row(2, "R5");

    // R4 R8: wrapping strides, second start ignored while busy
    burst(0, 5, 5, 3, 3, 5, 1, 7, 1);
    read_row(5, "R4"); read_row(8, "R4"); read_row(11, "R4");
    read_row(14, "R4"); read_row(1, "R8");

    // R7 R1: graded weights push sums past 8 bits
    burst(0, 3, 9, 0, 13, 0, 13, 0, 0);
    read_row(9, "R7");

    // R6: clear one row, neighbour untouched
    burst(1, 1, 2, 0, 4, 0, 4, 0, 0);
    read_row(2, "R6"); read_row(5, "R6");

    // R9: empty burst changes nothing
    burst(0, 0, 9, 1, 0, 1, 0, 1, 0);
    read_row(9, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule